// File: doc/BRIEF.md
# Maskable Read-Clear Interrupt Controller

This block gathers a set of level-sensitive fault sources and one event-type watchdog source into a status register. It drives an active-low interrupt request for a host. Each source has its own positive mask bit, and one global enable gates the whole block. When the host reads the status register, the block returns the pending causes and clears them on that same clock edge.

A level fault that is still present after a read does not come straight back. A hold-off state machine blocks level capture for a parameterized number of cycles, counted from the read strobe. The default count of 2000 cycles gives 10 µs at 200 MHz. The state machine has two states. ARMED is entered at reset and allows level capture. HOLDOFF blocks level capture and counts cycles. There are three transitions:
- ARMED to HOLDOFF on a read strobe.
- HOLDOFF to HOLDOFF on another read strobe, which restarts the count.
- HOLDOFF to ARMED when the count reaches its last value with no read strobe.

The watchdog source works differently. It is latched on the rising edge of its input, it is not affected by the hold-off, and it returns after a clear only when a new rising edge arrives.

Status and mask layout: bits `NUM_LEVEL-1..0` are the level faults, in source order. Bit `NUM_LEVEL` is the watchdog. With the defaults this is bits 6..0 for the level faults and bit 7 for the watchdog.

Top module: `intc_ctrl`

## Requirements
- R1: Reset clears every status bit, drives `intb_n` high and puts the hold-off state machine in ARMED.
- R2: While `irq_en` is 0, no source sets a status bit and `intb_n` stays high.
- R3: Masking is positive. A source whose mask bit is 0 never sets its status bit. An active level source with `irq_en` = 1, its mask bit 1 and the block ARMED sets its status bit on the next clock edge.
- R4: A level fault that is already active when its mask bit is raised sets its status bit on the first clock edge after the mask change.
- R5: `intb_n` is low exactly when `irq_en` is 1 and at least one status bit whose mask bit is 1 is set.
- R6: `stat_q` shows the pending causes during the cycle in which `stat_rd` is high. The clock edge that samples `stat_rd` clears all level bits, and it also clears the watchdog bit unless R10 applies.
- R7: After a read, level bits stay clear for `HOLD_CYCLES` clock edges. A level fault that is active throughout sets its bit again on edge `HOLD_CYCLES`+1 after the read edge.
- R8: A read during HOLDOFF restarts the hold-off count from that read.
- R9: The watchdog bit is set by a rising edge of `wdog_evt`, when its mask bit and `irq_en` are 1, and it stays set until a read. A `wdog_evt` held high does not set the bit again after a read.
- R10: A watchdog rising edge sampled on the same edge as a read leaves the watchdog bit set after that read.
- R11: A watchdog rising edge is captured during HOLDOFF, while level captures are still blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_lvl | input | NUM_LEVEL | Level-sensitive fault sources |
| wdog_evt | input | 1 | Watchdog timeout event (rising edge captured) |
| irq_mask | input | NUM_LEVEL+1 | Positive mask; bit NUM_LEVEL is the watchdog |
| irq_en | input | 1 | Global interrupt enable |
| stat_rd | input | 1 | Status read strobe, one cycle per read |
| stat_q | output | NUM_LEVEL+1 | Status register contents |
| intb_n | output | 1 | Interrupt request, active low |

## Verification
The main function is tried with four kinds of pattern:
- Several fault sets against several mask values. This separates the mask path from the global gate.
- Faults held through a read. This measures the exact re-assertion delay and shows whether a second read restarts it.
- A held watchdog input and watchdog edges placed on the read cycle and inside the hold-off. These separate one-shot capture from level capture.
- A long pseudo-random stretch of all inputs, compared cycle by cycle with a behavioural model. This covers the orderings that the directed cases do not reach.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [0:0] {
        ST_ARMED   = 1'b0,
        ST_HOLDOFF = 1'b1
    } hold_state_e;

endpackage

// File: rtl/intc_holdoff.sv
module intc_holdoff
    import intc_pkg::*;
#(
    parameter int HOLD_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    output logic armed
);

    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    hold_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // hold-off counter: restarts on every read, idle while armed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (rd_stb || state_q == ST_ARMED) cnt_q <= '0;
        else                                    cnt_q <= cnt_q + 1'b1;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (rd_stb) state_d = ST_HOLDOFF;
            ST_HOLDOFF: if (!rd_stb && cnt_q == LAST) state_d = ST_ARMED;
            default:    state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        armed = (state_q == ST_ARMED);
    end

endmodule

// File: rtl/intc_edge.sv
module intc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic rise
);

    logic evt_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_prev_q <= 1'b0;
        else        evt_prev_q <= evt;
    end

    assign rise = evt && !evt_prev_q;

endmodule

// File: rtl/intc_status_bank.sv
module intc_status_bank #(
    parameter int NUM_LEVEL = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LEVEL-1:0] lvl,
    input  logic                 wd_rise,
    input  logic [NUM_LEVEL:0]   mask,
    input  logic                 en,
    input  logic                 armed,
    input  logic                 rd,
    output logic [NUM_LEVEL:0]   stat
);

    localparam int WD_BIT = NUM_LEVEL;

    // level-driven bits: captured only while armed, cleared by a read
    for (genvar i = 0; i < NUM_LEVEL; i++) begin : g_lvl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             stat[i] <= 1'b0;
            else if (rd)                            stat[i] <= 1'b0;
            else if (armed && en && mask[i] && lvl[i]) stat[i] <= 1'b1;
        end
    end

    // event bit: a new capture wins over a coincident clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               stat[WD_BIT] <= 1'b0;
        else if (wd_rise && en && mask[WD_BIT])   stat[WD_BIT] <= 1'b1;
        else if (rd)                              stat[WD_BIT] <= 1'b0;
    end

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
    parameter int NUM_LEVEL   = 7,
    parameter int HOLD_CYCLES = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LEVEL-1:0] fault_lvl,
    input  logic                 wdog_evt,
    input  logic [NUM_LEVEL:0]   irq_mask,
    input  logic                 irq_en,
    input  logic                 stat_rd,
    output logic [NUM_LEVEL:0]   stat_q,
    output logic                 intb_n
);

    logic armed;
    logic wd_rise;

    intc_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (stat_rd),
        .armed  (armed)
    );

    intc_edge u_wd_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (wdog_evt),
        .rise  (wd_rise)
    );

    intc_status_bank #(.NUM_LEVEL(NUM_LEVEL)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (fault_lvl),
        .wd_rise (wd_rise),
        .mask    (irq_mask),
        .en      (irq_en),
        .armed   (armed),
        .rd      (stat_rd),
        .stat    (stat_q)
    );

    assign intb_n = !(irq_en && |(stat_q & irq_mask));

endmodule

// File: rtl/intc_ctrl_chk.sv
module intc_ctrl_chk #(
    parameter int NUM_LEVEL   = 7,
    parameter int HOLD_CYCLES = 2000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LEVEL-1:0] fault_lvl,
    input logic [NUM_LEVEL:0]   irq_mask,
    input logic                 irq_en,
    input logic                 stat_rd,
    input logic [NUM_LEVEL:0]   stat_q,
    input logic                 intb_n
);

    localparam int SW = $clog2(HOLD_CYCLES + 3);
    localparam logic [SW-1:0] SAT = SW'(HOLD_CYCLES + 2);

    // edges since the last read, saturating
    logic [SW-1:0] since_rd;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             since_rd <= SAT;
        else if (stat_rd)       since_rd <= SW'(1);
        else if (since_rd != SAT) since_rd <= since_rd + 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> stat_q == '0);

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> intb_n);

    // R3: a newly set level bit needs an active, masked-in source one edge earlier
    assert_level_needs_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q[NUM_LEVEL-1:0] & ~$past(stat_q[NUM_LEVEL-1:0]))
         & ~$past(fault_lvl & irq_mask[NUM_LEVEL-1:0])) == '0);

    assert_wd_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[NUM_LEVEL]) |-> $past(irq_mask[NUM_LEVEL] && irq_en));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> stat_q[NUM_LEVEL-1:0] == '0);

    assert_holdoff_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rd <= SW'(HOLD_CYCLES)) |-> stat_q[NUM_LEVEL-1:0] == '0);

    assert_wd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[NUM_LEVEL] && !stat_rd) |=> stat_q[NUM_LEVEL]);

endmodule

bind intc_ctrl intc_ctrl_chk #(
    .NUM_LEVEL   (NUM_LEVEL),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_lvl (fault_lvl),
    .irq_mask  (irq_mask),
    .irq_en    (irq_en),
    .stat_rd   (stat_rd),
    .stat_q    (stat_q),
    .intb_n    (intb_n)
);

// File: tb/test_intc_ctrl.sv
`timescale 1ns/100ps
module test_intc_ctrl;

    localparam int NL = 7;
    localparam int H  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] fault_lvl = '0;
    logic          wdog_evt = 1'b0;
    logic [NL:0]   irq_mask = '0;
    logic          irq_en = 1'b0;
    logic          stat_rd = 1'b0;
    logic [NL:0]   stat_q;
    logic          intb_n;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intc_ctrl #(.NUM_LEVEL(NL), .HOLD_CYCLES(H)) i_intc_ctrl (
        .clk(clk), .rst_n(rst_n), .fault_lvl(fault_lvl), .wdog_evt(wdog_evt),
        .irq_mask(irq_mask), .irq_en(irq_en), .stat_rd(stat_rd),
        .stat_q(stat_q), .intb_n(intb_n)
    );

    // behavioural reference model
    logic [NL:0] m_stat = '0;
    bit m_armed = 1'b1;
    int m_cnt = 0;
    bit m_wprev = 1'b0;

    always @(posedge clk) begin
        bit wcap;
        if (!rst_n) begin
            m_stat = '0; m_armed = 1'b1; m_cnt = 0; m_wprev = 1'b0;
        end else begin
            wcap = wdog_evt && !m_wprev && irq_mask[NL] && irq_en;
            m_wprev = wdog_evt;
            if (stat_rd) begin
                m_stat = '0;
                m_armed = 1'b0;
                m_cnt = 0;
            end else if (m_armed) begin
                if (irq_en) m_stat[NL-1:0] = m_stat[NL-1:0] | (fault_lvl & irq_mask[NL-1:0]);
            end else if (m_cnt == H - 1) begin
                m_armed = 1'b1;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            if (wcap) m_stat[NL] = 1'b1;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit exp_intb;
        if (rst_n && !done) begin
            exp_intb = !(irq_en && |(m_stat & irq_mask));
            check(stat_q == m_stat, cur_req, "model stat", int'(stat_q), int'(m_stat));
            check(intb_n == exp_intb, "R5", "model intb", int'(intb_n), int'(exp_intb));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // issue a read, then count edges until intb_n falls
    task automatic measure_holdoff(string req);
        int n = 0;
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        do begin
            step(1);
            n++;
        end while (intb_n && n < 100);
        check(n == H + 1, req, "re-assert delay", n, H + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        cur_req = "R1";
        check(stat_q == '0, "R1", "stat after reset", int'(stat_q), 0);
        check(intb_n == 1'b1, "R1", "intb after reset", int'(intb_n), 1);

        // R2: globally disabled
        cur_req = "R2";
        irq_mask = '1; fault_lvl = '1; wdog_evt = 1'b1;
        step(3);
        wdog_evt = 1'b0;
        step(1);
        check(stat_q == '0, "R2", "stat disabled", int'(stat_q), 0);
        check(intb_n == 1'b1, "R2", "intb disabled", int'(intb_n), 1);

        // R3: positive mask
        cur_req = "R3";
        irq_mask = 8'h01; fault_lvl = 7'h03; irq_en = 1'b1;
        step(2);
        check(stat_q == 8'h01, "R3", "masked capture", int'(stat_q), 8'h01);
        check(intb_n == 1'b0, "R5", "intb asserted", int'(intb_n), 0);

        // R4: fault already active when mask enabled
        cur_req = "R4";
        irq_mask = 8'h03;
        step(1);
        check(stat_q == 8'h03, "R4", "late mask capture", int'(stat_q), 8'h03);

        // R5: global gate and mask gate on output
        cur_req = "R5";
        irq_en = 1'b0;
        #1;
        check(intb_n == 1'b1, "R5", "intb gated off", int'(intb_n), 1);
        check(stat_q == 8'h03, "R5", "stat kept", int'(stat_q), 8'h03);
        irq_en = 1'b1;
        step(1);

        // R6: read returns then clears
        cur_req = "R6";
        stat_rd = 1'b1;
        #1;
        check(stat_q == 8'h03, "R6", "read data", int'(stat_q), 8'h03);
        step(1);
        stat_rd = 1'b0;
        check(stat_q == '0, "R6", "cleared by read", int'(stat_q), 0);

        // R7: minimum off time, fault still active
        cur_req = "R7";
        step(H + 3);
        measure_holdoff("R7");

        // R8: second read restarts the hold-off
        cur_req = "R8";
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        step(4);
        measure_holdoff("R8");

        // R9: watchdog one-shot
        cur_req = "R9";
        fault_lvl = '0;
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        step(H + 3);
        irq_mask = 8'h80;
        wdog_evt = 1'b1;
        step(1);
        check(stat_q == 8'h80, "R9", "wd latched", int'(stat_q), 8'h80);
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        step(H + 5);
        check(stat_q == '0, "R9", "held wd not re-set", int'(stat_q), 0);
        wdog_evt = 1'b0;
        step(1);
        wdog_evt = 1'b1;
        step(1);
        wdog_evt = 1'b0;
        check(stat_q == 8'h80, "R9", "new wd edge", int'(stat_q), 8'h80);

        // R10: wd edge on the read cycle stays pending
        cur_req = "R10";
        step(2);
        stat_rd = 1'b1; wdog_evt = 1'b1;
        step(1);
        stat_rd = 1'b0; wdog_evt = 1'b0;
        check(stat_q == 8'h80, "R10", "wd kept on read", int'(stat_q), 8'h80);

        // R11: wd captured during hold-off, levels blocked
        cur_req = "R11";
        irq_mask = 8'hFF; fault_lvl = 7'h10;
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        step(2);
        wdog_evt = 1'b1;
        step(1);
        wdog_evt = 1'b0;
        check(stat_q == 8'h80, "R11", "wd in hold-off", int'(stat_q), 8'h80);

        // mixed pseudo-random stretch, model compared every cycle
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            fault_lvl = NL'($urandom);
            wdog_evt  = ($urandom % 4) == 0;
            irq_mask  = 8'($urandom);
            irq_en    = ($urandom % 8) != 0;
            stat_rd   = ($urandom % 9) == 0;
            step(1);
        end
        stat_rd = 1'b0;
        step(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule